// File: doc/BRIEF.md
# Test Channel Drive and Strobe Formatter

This block sits behind one pin of a digital test channel. It runs on a fast clock, and a cycle-start pulse marks where each test cycle begins. At that pulse it captures the settings for the cycle: a data bit, a two-bit format code, a drive-or-compare choice, an expected bit, and the indices of the shared timing generators it will listen to. Those indices pick a leading edge, a trailing edge and a strobe point. The timing generators are common to many pins. Each generator reaches this block as a one-cycle enable pulse on a bus, and the pin only chooses which bus lines it follows.

In drive mode the block turns the captured bit into a registered, glitch-free drive level in one of four formats:

- Non-return (code 00): the bit is held for the whole cycle.
- Return-low (code 01): the bit is driven between the two edges, and 0 is driven outside them.
- Return-high (code 10): the bit is driven between the two edges, and 1 is driven outside them.
- Complement-surround (code 11): the inverted bit is driven before the leading edge, the true bit between the edges, and the inverted bit after the trailing edge.

In compare mode the driver is released. The first pulse of the chosen strobe generator samples the device pin, and a mismatch against the expected bit sets a sticky fail flag. Only a clear input resets that flag.

Top module: `pin_formatter`

## Requirements
- R1: After reset the drive level is 0, the drive enable is 0 and the fail flag is 0.
- R2: Format code 00 holds the captured data bit on the drive level from the cycle after the start pulse until the next start.
- R3: Format code 01 drives 0 before the leading edge, the data bit from the leading edge until the trailing edge, and 0 after it.
- R4: Format code 10 drives 1 before the leading edge, the data bit between the edges, and 1 after the trailing edge.
- R5: Format code 11 drives the inverted data bit before the leading edge, the data bit between the edges, and the inverted bit again after the trailing edge.
- R6: Format, data, mode, expected bit and generator selections are captured only on the start pulse. Changing them during a cycle leaves that cycle's waveform unchanged.
- R7: When the leading and trailing edges arrive in the same fast-clock cycle, format 01 stays at 0, format 10 stays at 1 and format 11 stays at the inverted bit for the whole cycle, with no pulse.
- R8: The drive enable is 1 for the whole cycle when compare mode was 0 at the start, and 0 for the whole cycle when it was 1.
- R9: In compare mode, only the first pulse of the selected strobe generator in a cycle samples the pin. A mismatch with the expected bit sets the fail flag one clock later. Later strobes in the same cycle are ignored.
- R10: The fail flag stays set until the clear input is high. Clear has priority over a mismatch in the same clock.
- R11: In drive mode, strobe pulses never set the fail flag.
- R12: Each edge role reacts only to the generator index it selected. Pulses on the other generator lines have no effect.
- R13: The drive level and the fail flag are registered. Each changes on the clock edge that samples the causing pulse and is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse starting a test cycle |
| gen_edge | input | NGEN | One-clock enable pulses from the shared timing generators |
| lead_sel | input | SELW | Generator index used for the leading edge |
| trail_sel | input | SELW | Generator index used for the trailing edge |
| strobe_sel | input | SELW | Generator index used for the strobe |
| fmt_sel | input | 2 | Format code (00, 01, 10, 11 as above) |
| drv_data | input | 1 | Data bit for the cycle |
| exp_data | input | 1 | Expected pin value in compare mode |
| cmp_mode | input | 1 | 1 selects compare mode, 0 selects drive mode |
| pin_in | input | 1 | Device pin value seen by the comparator |
| fail_clr | input | 1 | Clears the fail flag |
| drv_level | output | 1 | Drive level |
| drv_en | output | 1 | Drive enable (0 = released) |
| fail_flag | output | 1 | Sticky compare failure |

## Verification
The assertions assume three things about the inputs:

- No generator pulse arrives in the same clock as a start pulse. The block ignores edges in that clock, so a pulse there would be lost rather than wrong.
- Each cycle lasts long enough for its edges to arrive in leading-then-trailing order.
- The clear input is a plain level.

The stimulus keeps to these assumptions by placing every generator pulse at least one clock after its start pulse, and the trailing pulse two clocks after the leading one. In coincident cases both roles point at the same generator line, so one pulse serves as both edges.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;
  typedef enum logic [1:0] {
    FMT_NRZ = 2'b00,
    FMT_RZ  = 2'b01,
    FMT_RO  = 2'b10,
    FMT_SBC = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_PRE  = 2'b01,
    PH_MID  = 2'b10,
    PH_POST = 2'b11
  } phase_e;
endpackage

// File: rtl/pfmt_edge_pick.sv
module pfmt_edge_pick #(
  parameter int NGEN = 4,
  localparam int SELW = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic [NGEN-1:0] gen_edge,
  input  logic [SELW-1:0] sel,
  output logic            pulse
);
  logic [NGEN-1:0] hit;

  for (genvar g = 0; g < NGEN; g++) begin : g_dec
    assign hit[g] = gen_edge[g] & (sel == SELW'(g));
  end

  assign pulse = |hit;
endmodule

// File: rtl/pfmt_phase.sv
module pfmt_phase
  import pfmt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_start,
  input  logic   lead_p,
  input  logic   trail_p,
  output phase_e phase_nx,
  output phase_e phase_q
);
  always_comb begin
    phase_nx = phase_q;
    if (cyc_start) begin
      phase_nx = PH_PRE;
    end else begin
      unique case (phase_q)
        PH_PRE: begin
          if (lead_p && trail_p) phase_nx = PH_POST;
          else if (lead_p)       phase_nx = PH_MID;
        end
        PH_MID:  if (trail_p) phase_nx = PH_POST;
        default: phase_nx = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_nx;
  end

  // The trailing region is left only by a new cycle (R3)
  p_post_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_POST && !cyc_start) |=> (phase_q == PH_POST));

  // The middle region is entered only from the pre-edge region (R7)
  p_mid_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_PRE && !cyc_start) |=> (phase_q != PH_MID || $past(phase_q) == PH_MID));
endmodule

// File: rtl/pfmt_wave.sv
module pfmt_wave
  import pfmt_pkg::*;
(
  input  fmt_e   fmt,
  input  logic   data,
  input  phase_e phase,
  output logic   level
);
  logic in_window;

  assign in_window = (phase == PH_MID);

  always_comb begin
    if (phase == PH_IDLE) begin
      level = 1'b0;
    end else begin
      unique case (fmt)
        FMT_NRZ: level = data;
        FMT_RZ:  level = in_window ? data : 1'b0;
        FMT_RO:  level = in_window ? data : 1'b1;
        FMT_SBC: level = in_window ? data : ~data;
        default: level = data;
      endcase
    end
  end
endmodule

// File: rtl/pfmt_strobe.sv
module pfmt_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cmp_mode,
  input  logic exp_data,
  input  logic strobe_p,
  input  logic pin_in,
  input  logic fail_clr,
  output logic cmp_q,
  output logic fail_q
);
  logic exp_q, done_q;
  logic cmp_d, exp_d, done_d, fail_d;
  logic sample;

  assign sample = !cyc_start && strobe_p && cmp_q && !done_q;

  always_comb begin
    cmp_d  = cmp_q;
    exp_d  = exp_q;
    done_d = done_q;
    fail_d = fail_q;
    if (cyc_start) begin
      cmp_d  = cmp_mode;
      exp_d  = exp_data;
      done_d = 1'b0;
    end else if (sample) begin
      done_d = 1'b1;
      if (pin_in != exp_q) fail_d = 1'b1;
    end
    if (fail_clr) fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= 1'b0;
      exp_q  <= 1'b0;
      done_q <= 1'b1;
      fail_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      exp_q  <= exp_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  // Once a sample is taken, no further sample happens in this cycle (R9)
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cyc_start) |=> done_q);

  // The flag is sticky without a clear (R10)
  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !fail_clr) |=> fail_q);

  // A clear always wins (R10)
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_clr |=> !fail_q);

  // Drive mode never raises the flag (R11)
  p_drive_nofail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_q && !cmp_q) |=> !fail_q);
endmodule

// File: rtl/pin_formatter.sv
module pin_formatter
  import pfmt_pkg::*;
#(
  parameter int NGEN = 4,
  localparam int SELW = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic [NGEN-1:0] gen_edge,
  input  logic [SELW-1:0] lead_sel,
  input  logic [SELW-1:0] trail_sel,
  input  logic [SELW-1:0] strobe_sel,
  input  logic [1:0]      fmt_sel,
  input  logic            drv_data,
  input  logic            exp_data,
  input  logic            cmp_mode,
  input  logic            pin_in,
  input  logic            fail_clr,
  output logic            drv_level,
  output logic            drv_en,
  output logic            fail_flag
);
  fmt_e            fmt_q, fmt_d;
  logic            data_q, data_d;
  logic [SELW-1:0] lead_q, trail_q, strb_q;
  logic [SELW-1:0] lead_d, trail_d, strb_d;
  logic            en_q, en_d;
  logic            lvl_q, lvl_d;
  logic            lead_p, trail_p, strobe_p;
  logic            cmp_q;
  phase_e          phase_nx, phase_q;

  always_comb begin
    fmt_d   = fmt_q;
    data_d  = data_q;
    lead_d  = lead_q;
    trail_d = trail_q;
    strb_d  = strb_q;
    en_d    = en_q;
    if (cyc_start) begin
      fmt_d   = fmt_e'(fmt_sel);
      data_d  = drv_data;
      lead_d  = lead_sel;
      trail_d = trail_sel;
      strb_d  = strobe_sel;
      en_d    = ~cmp_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= FMT_NRZ;
      data_q  <= 1'b0;
      lead_q  <= '0;
      trail_q <= '0;
      strb_q  <= '0;
      en_q    <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      fmt_q   <= fmt_d;
      data_q  <= data_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
      strb_q  <= strb_d;
      en_q    <= en_d;
      lvl_q   <= lvl_d;
    end
  end

  pfmt_edge_pick #(.NGEN(NGEN)) u_lead (
    .gen_edge(gen_edge), .sel(lead_q), .pulse(lead_p));
  pfmt_edge_pick #(.NGEN(NGEN)) u_trail (
    .gen_edge(gen_edge), .sel(trail_q), .pulse(trail_p));
  pfmt_edge_pick #(.NGEN(NGEN)) u_strobe (
    .gen_edge(gen_edge), .sel(strb_q), .pulse(strobe_p));

  pfmt_phase u_phase (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .lead_p(lead_p), .trail_p(trail_p),
    .phase_nx(phase_nx), .phase_q(phase_q));

  pfmt_wave u_wave (
    .fmt(fmt_d), .data(data_d), .phase(phase_nx), .level(lvl_d));

  pfmt_strobe u_cmp (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .cmp_mode(cmp_mode), .exp_data(exp_data), .strobe_p(strobe_p),
    .pin_in(pin_in), .fail_clr(fail_clr),
    .cmp_q(cmp_q), .fail_q(fail_flag));

  assign drv_level = lvl_q;
  assign drv_en    = en_q;

  // Drive enable only moves on a cycle start (R8)
  p_en_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(drv_en));

  // Enable and compare mode agree once a cycle is running (R8)
  p_en_vs_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (drv_en == !cmp_q));

  // Non-return format holds its level inside a cycle (R2)
  p_nrz_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == FMT_NRZ && phase_q != PH_IDLE && !cyc_start) |=> $stable(drv_level));

  // Return-low format is never high outside the edge window (R3)
  p_rz_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == FMT_RZ && (phase_q == PH_PRE || phase_q == PH_POST)) |-> !drv_level);
endmodule

// File: tb/pin_formatter_test.sv
module pin_formatter_test;
  localparam int NGEN = 4;
  localparam int SELW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cyc_start;
  logic [NGEN-1:0] gen_edge;
  logic [SELW-1:0] lead_sel, trail_sel, strobe_sel;
  logic [1:0]      fmt_sel;
  logic            drv_data, exp_data, cmp_mode, pin_in, fail_clr;
  logic            drv_level, drv_en, fail_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_formatter #(.NGEN(NGEN)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .gen_edge(gen_edge),
    .lead_sel(lead_sel), .trail_sel(trail_sel), .strobe_sel(strobe_sel),
    .fmt_sel(fmt_sel), .drv_data(drv_data), .exp_data(exp_data),
    .cmp_mode(cmp_mode), .pin_in(pin_in), .fail_clr(fail_clr),
    .drv_level(drv_level), .drv_en(drv_en), .fail_flag(fail_flag));

  // {fmt, data, lead, trail, noise gen, expected before/inside/after}
  localparam logic [11:0] TBL [12] = '{
    {2'd0, 1'b1, 2'd0, 2'd1, 2'd3, 3'b111},
    {2'd0, 1'b0, 2'd2, 2'd3, 2'd1, 3'b000},
    {2'd1, 1'b1, 2'd0, 2'd1, 2'd2, 3'b010},
    {2'd1, 1'b0, 2'd1, 2'd2, 2'd0, 3'b000},
    {2'd2, 1'b0, 2'd0, 2'd1, 2'd3, 3'b101},
    {2'd2, 1'b1, 2'd2, 2'd3, 2'd0, 3'b111},
    {2'd3, 1'b1, 2'd0, 2'd1, 2'd2, 3'b010},
    {2'd3, 1'b0, 2'd3, 2'd0, 2'd1, 3'b101},
    {2'd1, 1'b1, 2'd2, 2'd2, 2'd0, 3'b000},
    {2'd2, 1'b0, 2'd1, 2'd1, 2'd3, 3'b111},
    {2'd3, 1'b1, 2'd0, 2'd0, 2'd3, 3'b000},
    {2'd3, 1'b0, 2'd2, 2'd2, 2'd1, 3'b111}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Inputs are applied at a falling edge; outputs are read one falling edge later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    gen_edge  = '0;
    fail_clr  = 1'b0;
  endtask

  task automatic start(input logic [1:0] f, input logic d, input logic [1:0] l,
                       input logic [1:0] t, input logic [1:0] s,
                       input logic cm, input logic ex);
    cyc_start = 1'b1;
    fmt_sel = f; drv_data = d; lead_sel = l; trail_sel = t;
    strobe_sel = s; cmp_mode = cm; exp_data = ex;
    tick();
  endtask

  task automatic pulse(input int g);
    gen_edge = NGEN'(1) << g;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; cyc_start = 1'b0; gen_edge = '0;
    lead_sel = '0; trail_sel = '0; strobe_sel = '0; fmt_sel = 2'b00;
    drv_data = 1'b0; exp_data = 1'b0; cmp_mode = 1'b0; pin_in = 1'b0; fail_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 level", drv_level, 1'b0);
    check("R1 enable", drv_en, 1'b0);
    check("R1 fail", fail_flag, 1'b0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 12; i++) begin
      logic [11:0] e;
      string tg;
      e = TBL[i];
      case (e[11:10])
        2'd0:    tg = "R2";
        2'd1:    tg = "R3";
        2'd2:    tg = "R4";
        default: tg = "R5";
      endcase
      if (e[8:7] == e[6:5]) tg = "R7";
      start(e[11:10], e[9], e[8:7], e[6:5], 2'd0, 1'b0, 1'b0);
      check({tg, " before"}, drv_level, e[2]);
      check("R8 enable in drive mode", drv_en, 1'b1);
      pulse(e[4:3]);
      check({tg, " R12 other generator"}, drv_level, e[2]);
      pulse(e[8:7]);
      check({tg, " R13 after lead"}, drv_level, e[1]);
      tick();
      check({tg, " inside"}, drv_level, e[1]);
      pulse(e[6:5]);
      check({tg, " after trail"}, drv_level, e[0]);
      tick();
      check({tg, " end"}, drv_level, e[0]);
    end

    // R6: settings changed mid-cycle are not taken
    start(2'd1, 1'b1, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0);
    fmt_sel = 2'd0; drv_data = 1'b0; lead_sel = 2'd3; cmp_mode = 1'b1;
    pulse(0);
    check("R6 latched data inside", drv_level, 1'b1);
    check("R6 latched mode", drv_en, 1'b1);
    pulse(1);
    check("R6 latched format after", drv_level, 1'b0);

    // R9 / R8: compare mode, mismatch sets the flag
    pin_in = 1'b0;
    start(2'd0, 1'b0, 2'd0, 2'd1, 2'd2, 1'b1, 1'b1);
    check("R8 enable in compare mode", drv_en, 1'b0);
    check("R9 no flag before strobe", fail_flag, 1'b0);
    pulse(1);
    check("R12 unselected strobe", fail_flag, 1'b0);
    pulse(2);
    check("R9 mismatch sets flag", fail_flag, 1'b1);
    tick(); tick();
    check("R10 sticky", fail_flag, 1'b1);
    fail_clr = 1'b1;
    tick();
    check("R10 clear", fail_flag, 1'b0);

    // R10: clear beats a mismatch in the same clock
    start(2'd0, 1'b0, 2'd0, 2'd1, 2'd2, 1'b1, 1'b1);
    gen_edge = 4'b0100; fail_clr = 1'b1;
    tick();
    check("R10 clear priority", fail_flag, 1'b0);

    // R9: only the first strobe in a cycle counts
    start(2'd0, 1'b0, 2'd0, 2'd1, 2'd3, 1'b1, 1'b0);
    pin_in = 1'b0;
    pulse(3);
    check("R9 match first strobe", fail_flag, 1'b0);
    pin_in = 1'b1;
    pulse(3);
    check("R9 second strobe ignored", fail_flag, 1'b0);

    // R11: drive mode strobes never fail
    start(2'd0, 1'b1, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0);
    pin_in = 1'b1;
    pulse(2);
    check("R11 drive mode no fail", fail_flag, 1'b0);
    check("R11 drive still enabled", drv_en, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule